// File: doc/BRIEF.md
# Exhaustive Stuck-at Fault Sweeper

This block tests a small combinational decoder for a single stuck-at-0 or stuck-at-1 defect. It drives the decoder's select inputs through every code, and for each code it compares the observed output word with the word a fault-free decoder would give. The fault-free word comes from a golden decoder model inside the block. The decoder under test is wired to plain ports: `uut_in` drives its select lines and `uut_out` returns its output lines. Which fault site inside the decoder is active is set elsewhere, and at most one fault is assumed during a run.

A single-cycle `start` pulse, taken only while the block is idle, begins a run. Codes are applied in ascending order, one per clock. Each output word is registered one cycle after its code is applied, and the difference is judged in the following cycle. When the sweep ends, the block raises `done` and reports three results: whether any code disagreed, the lowest disagreeing code, and how many codes disagreed. The model is purely logical, so no path delay is measured. A missing active line, an extra active line and a wrong active line all count as a disagreement.

Top module: `stuck_fault_sweeper`

## Requirements
- R1: A synchronous active-high reset clears `busy`, `done`, `detected`, `first_fail_vec`, `fail_count` and `uut_in` to zero, including when it arrives in the middle of a run.
- R2: `start` sampled high while idle begins a run. From the next clock edge, `uut_in` holds 0, then rises by one each cycle up to `2**SEL_W-1`, and `busy` is high throughout.
- R3: The expected word for code k has only bit k at 1 (with `ACTIVE_LOW`=0). The observed word is sampled at the end of the cycle in which code k is on `uut_in`.
- R4: Any bit difference between the observed and expected words counts as a failure. This includes an all-zero word and a word with two lines active.
- R5: `fail_count` equals the number of failing codes in the run, from 0 up to `2**SEL_W`.
- R6: `detected` is 1 exactly when `fail_count` is nonzero. `first_fail_vec` holds the lowest failing code and reads 0 while `detected` is 0.
- R7: `done` rises, and `busy` falls, on the 17th clock edge after the edge that took `start` (`2**SEL_W+1` in general). The results then hold until the next accepted start or a reset.
- R8: A `start` pulse while `busy` is high is ignored. The code sequence is not restarted, and the results and the timing of `done` are unchanged.
- R9: An accepted start clears `done`, `detected`, `first_fail_vec` and `fail_count` on the same edge that applies code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, taken only while idle |
| uut_in | output | SEL_W | Select code driven to the decoder under test |
| uut_out | input | 2**SEL_W | Output word returned by the decoder under test |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished and the results are valid |
| detected | output | 1 | At least one code disagreed |
| first_fail_vec | output | SEL_W | Lowest disagreeing code; 0 when nothing was detected |
| fail_count | output | SEL_W+1 | Number of disagreeing codes |

## Verification
Take the edge that samples `start` as edge 0. Code k then appears on `uut_in` after edge k, its output word is registered at edge k+1, and its verdict reaches the result registers at edge k+2. For the default width, `done` therefore rises at edge 17. The bench drives inputs and samples outputs only on falling clock edges. It counts rising edges from the start edge: it checks `uut_in` after each of edges 0 to 15, checks that `done` is still low after edge 16, and reads the final results after edge 17. Start pulses during a run and resets in mid-run are placed at known edge counts, so the expected state at each sample point is fixed in advance.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_APPLY = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_e;

   localparam int unsigned SEL_W_MIN = 1;
   localparam int unsigned SEL_W_MAX = 8;

endpackage

// File: rtl/sfs_vector_seq.sv
module sfs_vector_seq
   import sfs_pkg::*;
#(
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic [SEL_W-1:0] vec,
   output logic             launch,
   output logic             apply_valid,
   output logic             finish,
   output logic             busy
);

   localparam logic [SEL_W-1:0] VEC_LAST = {SEL_W{1'b1}};

   seq_state_e state_q;

   assign launch      = start && (state_q == SEQ_IDLE);
   assign apply_valid = (state_q == SEQ_APPLY);
   assign finish      = (state_q == SEQ_DRAIN);
   assign busy        = (state_q != SEQ_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         vec     <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (launch) begin
                  state_q <= SEQ_APPLY;
                  vec     <= '0;
               end
            end
            SEQ_APPLY: begin
               if (vec == VEC_LAST) begin
                  state_q <= SEQ_DRAIN;
               end else begin
                  vec <= vec + SEL_W'(1);
               end
            end
            SEQ_DRAIN: state_q <= SEQ_IDLE;
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R2: codes advance by exactly one per cycle while applying
   a_r2_vec_step: assert property (@(posedge clk) disable iff (rst)
      (apply_valid && vec != VEC_LAST) |=> (vec == $past(vec) + SEL_W'(1)));

   // R8: a start seen during a run never sends the sequence back to code 0
   a_r8_start_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> (vec != '0));

   // R1: reset returns the sequencer to idle at code 0
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!busy && vec == '0));

endmodule

// File: rtl/sfs_golden.sv
module sfs_golden #(
   parameter int unsigned SEL_W      = 4,
   parameter bit          ACTIVE_LOW = 1'b0,
   localparam int unsigned OUT_W     = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] vec,
   output logic [OUT_W-1:0] expected
);

   logic [OUT_W-1:0] line_hi;

   for (genvar i = 0; i < OUT_W; i++) begin : g_line
      assign line_hi[i] = (vec == SEL_W'(i));
   end

   if (ACTIVE_LOW) begin : g_low
      assign expected = ~line_hi;
   end else begin : g_high
      assign expected = line_hi;
   end

   // R3: the model always names exactly one line
   always_comb begin
      if (!$isunknown(vec)) begin
         a_r3_golden_one_line: assert ($countones(line_hi) == 1);
      end
   end

endmodule

// File: rtl/sfs_compare.sv
module sfs_compare #(
   parameter int unsigned SEL_W  = 4,
   localparam int unsigned OUT_W = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             apply_valid,
   input  logic [SEL_W-1:0] vec,
   input  logic [OUT_W-1:0] observed,
   input  logic [OUT_W-1:0] expected,
   output logic             miss,
   output logic [SEL_W-1:0] miss_vec
);

   logic             cap_valid;
   logic [OUT_W-1:0] cap_diff;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_valid <= 1'b0;
         cap_diff  <= '0;
         miss_vec  <= '0;
      end else begin
         cap_valid <= apply_valid;
         if (apply_valid) begin
            cap_diff <= observed ^ expected;
            miss_vec <= vec;
         end
      end
   end

   assign miss = cap_valid && (|cap_diff);

   // R4: a verdict only follows a cycle in which a code was applied
   a_r4_miss_after_apply: assert property (@(posedge clk) disable iff (rst)
      miss |-> $past(apply_valid));

endmodule

// File: rtl/sfs_result.sv
module sfs_result #(
   parameter int unsigned SEL_W  = 4,
   localparam int unsigned OUT_W = 1 << SEL_W,
   localparam int unsigned CNT_W = SEL_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             launch,
   input  logic             finish,
   input  logic             miss,
   input  logic [SEL_W-1:0] miss_vec,
   output logic             done,
   output logic             detected,
   output logic [SEL_W-1:0] first_fail_vec,
   output logic [CNT_W-1:0] fail_count
);

   always_ff @(posedge clk) begin
      if (rst || launch) begin
         done           <= 1'b0;
         detected       <= 1'b0;
         first_fail_vec <= '0;
         fail_count     <= '0;
      end else begin
         if (miss) begin
            fail_count <= fail_count + CNT_W'(1);
            if (!detected) begin
               detected       <= 1'b1;
               first_fail_vec <= miss_vec;
            end
         end
         if (finish) begin
            done <= 1'b1;
         end
      end
   end

   // R5: the count never passes the number of codes
   a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
      fail_count <= CNT_W'(OUT_W));

   // R5: every failing code adds exactly one
   a_r5_miss_counted: assert property (@(posedge clk) disable iff (rst)
      (miss && !launch) |=> (fail_count == $past(fail_count) + CNT_W'(1)));

   // R6: detection flag and count agree
   a_r6_flag_matches_count: assert property (@(posedge clk) disable iff (rst)
      detected == (fail_count != '0));

   // R6: the first failing code is kept once recorded
   a_r6_first_sticky: assert property (@(posedge clk) disable iff (rst)
      (detected && !launch) |=> (detected && $stable(first_fail_vec)));

   // R7: the drain cycle always ends in done
   a_r7_finish_sets_done: assert property (@(posedge clk) disable iff (rst)
      finish |=> done);

endmodule

// File: rtl/stuck_fault_sweeper.sv
module stuck_fault_sweeper #(
   parameter int unsigned SEL_W      = 4,
   parameter bit          ACTIVE_LOW = 1'b0,
   localparam int unsigned OUT_W     = 1 << SEL_W,
   localparam int unsigned CNT_W     = SEL_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic [SEL_W-1:0] uut_in,
   input  logic [OUT_W-1:0] uut_out,
   output logic             busy,
   output logic             done,
   output logic             detected,
   output logic [SEL_W-1:0] first_fail_vec,
   output logic [CNT_W-1:0] fail_count
);

   if (SEL_W < sfs_pkg::SEL_W_MIN || SEL_W > sfs_pkg::SEL_W_MAX) begin : g_bad_width
      $error("stuck_fault_sweeper: SEL_W out of supported range");
   end

   logic             launch;
   logic             apply_valid;
   logic             finish;
   logic [OUT_W-1:0] expected;
   logic             miss;
   logic [SEL_W-1:0] miss_vec;

   sfs_vector_seq #(.SEL_W(SEL_W)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .vec         (uut_in),
      .launch      (launch),
      .apply_valid (apply_valid),
      .finish      (finish),
      .busy        (busy)
   );

   sfs_golden #(.SEL_W(SEL_W), .ACTIVE_LOW(ACTIVE_LOW)) u_golden (
      .vec      (uut_in),
      .expected (expected)
   );

   sfs_compare #(.SEL_W(SEL_W)) u_cmp (
      .clk         (clk),
      .rst         (rst),
      .apply_valid (apply_valid),
      .vec         (uut_in),
      .observed    (uut_out),
      .expected    (expected),
      .miss        (miss),
      .miss_vec    (miss_vec)
   );

   sfs_result #(.SEL_W(SEL_W)) u_res (
      .clk            (clk),
      .rst            (rst),
      .launch         (launch),
      .finish         (finish),
      .miss           (miss),
      .miss_vec       (miss_vec),
      .done           (done),
      .detected       (detected),
      .first_fail_vec (first_fail_vec),
      .fail_count     (fail_count)
   );

   // R7: results are never reported while a run is still going
   a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   // R9: an accepted start clears the previous results
   a_r9_launch_clears: assert property (@(posedge clk) disable iff (rst)
      launch |=> (!done && !detected && fail_count == '0));

endmodule

// File: tb/stuck_fault_sweeper_test.sv
`timescale 1ns/1ps
module stuck_fault_sweeper_test;

   localparam int M_NONE  = 0;
   localparam int M_Y_ALL = 1;
   localparam int M_X_UP  = 2;
   localparam int M_X_LO  = 3;
   localparam int M_W_ALL = 4;
   localparam int M_W_LO  = 5;
   localparam int M_W_NOT = 6;
   localparam int M_EN_UP = 7;
   localparam int M_D5    = 8;
   localparam int M_D15   = 9;
   localparam int M_DEAD  = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [3:0]  uut_in;
   logic [15:0] uut_out;
   logic        busy, done, detected;
   logic [3:0]  first_fail_vec;
   logic [4:0]  fail_count;
   int          mode = M_NONE;
   int          checks = 0;
   int          fails = 0;

   always #2 clk = ~clk;

   stuck_fault_sweeper uut (
      .clk(clk), .rst(rst), .start(start), .uut_in(uut_in), .uut_out(uut_out),
      .busy(busy), .done(done), .detected(detected),
      .first_fail_vec(first_fail_vec), .fail_count(fail_count)
   );

   // 4-to-16 decoder built from two 3-to-8 halves, with one injectable fault
   function automatic logic [15:0] faulty_dec(input logic [3:0] v, input int m);
      logic       w, en_up, en_lo;
      logic [2:0] lo_up, lo_lo;
      logic [15:0] o;
      w = v[3];
      lo_up = v[2:0];
      lo_lo = v[2:0];
      if (m == M_Y_ALL) begin lo_up[1] = 1'b0; lo_lo[1] = 1'b0; end
      if (m == M_X_UP) lo_up[2] = 1'b0;
      if (m == M_X_LO) lo_lo[2] = 1'b0;
      if (m == M_W_ALL) w = 1'b0;
      en_up = ~w;
      en_lo = w;
      if (m == M_W_LO) en_lo = 1'b0;
      if (m == M_W_NOT) en_up = 1'b1;
      if (m == M_EN_UP) en_up = 1'b0;
      o = '0;
      if (en_up) o[lo_up] = 1'b1;
      if (en_lo) o[8 + int'(lo_lo)] = 1'b1;
      if (m == M_D5) o[5] = 1'b0;
      if (m == M_D15) o[15] = 1'b0;
      if (m == M_DEAD) o = '0;
      return o;
   endfunction

   assign uut_out = faulty_dec(uut_in, mode);

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_results(input string req, input int det, input int first, input int cnt);
      chk(req, "done", int'(done), 1);
      chk(req, "busy", int'(busy), 0);
      chk(req, "detected", int'(detected), det);
      chk(req, "first_fail_vec", int'(first_fail_vec), first);
      chk(req, "fail_count", int'(fail_count), cnt);
   endtask

   // full run: start edge, then 16 edges (done still low), then edge 17
   task automatic run_sweep(input string req, input int m, input int det, input int first, input int cnt);
      mode = m;
      pulse_start();
      repeat (16) @(posedge clk);
      @(negedge clk);
      chk("R7", "done before edge 17", int'(done), 0);
      @(posedge clk);
      @(negedge clk);
      check_results(req, det, first, cnt);
   endtask

   task automatic t_reset_state();
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "detected", int'(detected), 0);
      chk("R1", "fail_count", int'(fail_count), 0);
      chk("R1", "first_fail_vec", int'(first_fail_vec), 0);
      chk("R1", "uut_in", int'(uut_in), 0);
   endtask

   task automatic t_vector_order();
      mode = M_NONE;
      pulse_start();
      for (int k = 0; k < 16; k++) begin
         chk("R2", "uut_in step", int'(uut_in), k);
         chk("R2", "busy", int'(busy), 1);
         @(posedge clk);
         @(negedge clk);
      end
      chk("R7", "busy at edge 16", int'(busy), 1);
      @(posedge clk);
      @(negedge clk);
      check_results("R3", 0, 0, 0);
   endtask

   task automatic t_start_during_run();
      mode = M_D5;
      pulse_start();
      repeat (5) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R8", "uut_in continues", int'(uut_in), 6);
      repeat (10) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check_results("R8", 1, 5, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "no relaunch from drain", int'(busy), 0);
   endtask

   task automatic t_rerun_clears();
      mode = M_DEAD;
      run_sweep("R5", M_DEAD, 1, 0, 16);
      mode = M_NONE;
      pulse_start();
      chk("R9", "done cleared", int'(done), 0);
      chk("R9", "detected cleared", int'(detected), 0);
      chk("R9", "fail_count cleared", int'(fail_count), 0);
      chk("R9", "first_fail_vec cleared", int'(first_fail_vec), 0);
      repeat (17) @(posedge clk);
      @(negedge clk);
      check_results("R9", 0, 0, 0);
   endtask

   task automatic t_reset_mid_run();
      mode = M_DEAD;
      pulse_start();
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R1", "fail_count before reset", int'(fail_count), 5);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R1", "stays idle after reset", int'(busy), 0);
      chk("R1", "no done after reset", int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_vector_order();
      run_sweep("R6", M_NONE, 0, 0, 0);
      run_sweep("R4", M_Y_ALL, 1, 2, 8);
      run_sweep("R6", M_X_UP, 1, 4, 4);
      run_sweep("R6", M_X_LO, 1, 12, 4);
      run_sweep("R5", M_W_ALL, 1, 8, 8);
      run_sweep("R4", M_W_LO, 1, 8, 8);
      run_sweep("R4", M_W_NOT, 1, 8, 8);
      run_sweep("R6", M_EN_UP, 1, 0, 8);
      run_sweep("R5", M_D5, 1, 5, 1);
      run_sweep("R6", M_D15, 1, 15, 1);
      t_start_during_run();
      t_rerun_clears();
      t_reset_mid_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule